// File: doc/BRIEF.md
# Reshapeable Dual-Port Memory Block

This block holds 256 bits of storage. It has one write port and one read port, and the two ports run on independent clocks. A static shape input chooses how the bits are seen. With the input low, the array is 32 words of 8 bits. With it high, the array is 64 words of 4 bits. Both ports always carry a 6-bit address and an 8-bit data bus.

In the narrow shape, the array is still 32 rows of 8 bits. The upper five address bits pick the row and the lowest address bit picks one half of it. Data written in one shape can therefore be read back in the other.

A separate parameter for each port chooses whether that port acts on the rising or the falling clock edge. A block enable qualifies every access on both ports. Reads are registered: the read output changes only on an active, enabled read edge and otherwise holds its value. An active-low reset clears only the read output register; the array itself is not reset.

Top module: `dpram_shape`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 8'h00.
- R2: With `shape_nib`=0, an active write edge with `wr_en`=1 and `blk_en`=1 stores `wr_data[7:0]` into row `wr_addr[4:0]`; `wr_addr[5]` is ignored.
- R3: With `shape_nib`=0, an active read edge with `rd_en`=1 and `blk_en`=1 loads row `rd_addr[4:0]` into `rd_data`; `rd_addr[5]` is ignored.
- R4: With `shape_nib`=1, an enabled write stores `wr_data[3:0]` into row `wr_addr[5:1]`. It writes bits [3:0] of that row when `wr_addr[0]`=0 and bits [7:4] when `wr_addr[0]`=1, and it leaves the other half of the row unchanged.
- R5: With `shape_nib`=1, an enabled read drives the half of row `rd_addr[5:1]` selected by `rd_addr[0]` onto `rd_data[3:0]`, and drives 4'h0 onto `rd_data[7:4]`.
- R6: No storage changes at a write edge where `wr_en`=0 or `blk_en`=0.
- R7: `rd_data` holds its value across a read edge where `rd_en`=0 or `blk_en`=0.
- R8: A read and a write to the same location on the same active edge return the value stored before that edge.
- R9: Parameters `WR_RISE` and `RD_RISE` select the active edge of each port: 1 means rising, 0 means falling.
- R10: Both shapes see the same storage. Byte row r is nibble address 2r (bits [3:0]) and nibble address 2r+1 (bits [7:4]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| rd_clk | input | 1 | Read port clock |
| rst_n | input | 1 | Active-low asynchronous clear of the read output |
| shape_nib | input | 1 | 0: 32x8 shape, 1: 64x4 shape |
| blk_en | input | 1 | Block enable for both ports |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is a read and a write that hit the same location on the same active edge. The case must be checked on both edge polarities at once. The bench drives one clock into two instances: one acts on rising edges and the other on falling edges. Inputs change a quarter period after each rising edge, so every stimulus is captured on the falling edge first and on the following rising edge second. The stimulus then writes a half row in the narrow shape, over a byte written earlier, and reads the full row back in the wide shape. This shows that the untouched half survived.

// File: rtl/dpram_shape.sv
module dpram_shape #(
  parameter int WIDTH   = 8,
  parameter int ADDR_W  = 6,
  parameter bit WR_RISE = 1'b1,
  parameter bit RD_RISE = 1'b1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              shape_nib,
  input  logic              blk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data
);
  localparam int ROWS = 2 ** (ADDR_W - 1);
  localparam int RW   = ADDR_W - 1;
  localparam int NIB  = WIDTH / 2;

  logic          wclk_i, rclk_i;
  logic          wr_go, rd_go;
  logic [RW-1:0] wrow, rrow;
  logic [WIDTH-1:0] wnext, rword, rsel;
  logic [WIDTH-1:0] mem [ROWS];

  // R9
  assign wclk_i = WR_RISE ? wr_clk : ~wr_clk;
  assign rclk_i = RD_RISE ? rd_clk : ~rd_clk;

  assign wr_go = wr_en & blk_en;
  assign rd_go = rd_en & blk_en;

  assign wrow = shape_nib ? wr_addr[ADDR_W-1:1] : wr_addr[RW-1:0];
  assign rrow = shape_nib ? rd_addr[ADDR_W-1:1] : rd_addr[RW-1:0];

  // R2 R4
  always_comb begin
    wnext = wr_data;
    if (shape_nib) begin
      if (wr_addr[0]) wnext = {wr_data[NIB-1:0], mem[wrow][NIB-1:0]};
      else            wnext = {mem[wrow][WIDTH-1:NIB], wr_data[NIB-1:0]};
    end
  end

  always_ff @(posedge wclk_i)
    if (wr_go) mem[wrow] <= wnext;

  // R3 R5
  assign rword = mem[rrow];
  assign rsel  = !shape_nib ? rword :
                 rd_addr[0] ? {{NIB{1'b0}}, rword[WIDTH-1:NIB]} :
                              {{NIB{1'b0}}, rword[NIB-1:0]};

  // R1 R7 R8
  always_ff @(posedge rclk_i or negedge rst_n)
    if (!rst_n)     rd_data <= '0;
    else if (rd_go) rd_data <= rsel;

  // R2
  byte_wr_chk: assert property (@(posedge wclk_i) disable iff (!rst_n)
    (!shape_nib && wr_go) |=> mem[$past(wr_addr[RW-1:0])] == $past(wr_data));

  // R4
  nib_keep_chk: assert property (@(posedge wclk_i) disable iff (!rst_n)
    (shape_nib && wr_go && !wr_addr[0]) |=>
      mem[$past(wr_addr[ADDR_W-1:1])][WIDTH-1:NIB] == $past(mem[wr_addr[ADDR_W-1:1]][WIDTH-1:NIB]));

  // R6
  no_wr_chk: assert property (@(posedge wclk_i) disable iff (!rst_n)
    !wr_go |=> mem[$past(wrow)] == $past(mem[wrow]));

  // R7
  rd_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_n)
    !rd_go |=> $stable(rd_data));

  // R5
  nib_upper_chk: assert property (@(posedge rclk_i) disable iff (!rst_n)
    (shape_nib && rd_go) |=> rd_data[WIDTH-1:NIB] == '0);

  // R3 R8
  byte_rd_chk: assert property (@(posedge rclk_i) disable iff (!rst_n)
    (!shape_nib && rd_go) |=> rd_data == $past(mem[rd_addr[RW-1:0]]));
endmodule

// File: tb/sim_dpram_shape.sv
module sim_dpram_shape;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shape_nib = 1'b0, blk_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_a, rd_b;
  logic [7:0] model [32];
  logic [7:0] exp_rd = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpram_shape u0 (.wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .shape_nib(shape_nib),
    .blk_en(blk_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_a));

  // R9: falling-edge instance
  dpram_shape #(.WR_RISE(1'b0), .RD_RISE(1'b0)) u1 (.wr_clk(clk), .rd_clk(clk),
    .rst_n(rst_n), .shape_nib(shape_nib), .blk_en(blk_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_b));

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] mread(input logic [5:0] a);
    if (!shape_nib) return model[a[4:0]];
    return a[0] ? {4'h0, model[a[5:1]][7:4]} : {4'h0, model[a[5:1]][3:0]};
  endfunction

  task automatic cyc(input bit we, input logic [5:0] wa, input logic [7:0] wd,
                     input bit re, input logic [5:0] ra, input bit blk, input string tag);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra; blk_en = blk;
    if (re && blk) exp_rd = mread(ra);
    if (we && blk) begin
      if (!shape_nib) model[wa[4:0]] = wd;
      else if (wa[0]) model[wa[5:1]][7:4] = wd[3:0];
      else            model[wa[5:1]][3:0] = wd[3:0];
    end
    @(posedge clk); #1;
    check({tag, " rise"}, rd_a, exp_rd);
    check({tag, " fall R9"}, rd_b, exp_rd);
  endtask

  task automatic t_reset;
    check("R1 rise", rd_a, 8'h00);
    check("R1 fall", rd_b, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 32; i++) cyc(1, 6'(i), 8'(i * 7 + 3), 0, 0, 1, "init R2");
  endtask

  task automatic t_byte;
    shape_nib = 0;
    cyc(1, 6'd5, 8'hA5, 0, 0, 1, "R2");
    cyc(1, 6'd37, 8'h5A, 1, 6'd5, 1, "R2 R3");
    cyc(0, 0, 0, 1, 6'd5, 1, "R2 bit5 ignored");
    cyc(0, 0, 0, 1, 6'd37, 1, "R3 bit5 ignored");
    cyc(1, 6'd31, 8'hFF, 1, 6'd0, 1, "R3");
    cyc(0, 0, 0, 1, 6'd31, 1, "R2 top row");
  endtask

  task automatic t_nibble;
    shape_nib = 0;
    cyc(1, 6'd3, 8'h3C, 0, 0, 1, "R10 prep");
    shape_nib = 1;
    cyc(1, 6'd6, 8'hFA, 0, 0, 1, "R4 low");
    cyc(0, 0, 0, 1, 6'd6, 1, "R5 low");
    cyc(0, 0, 0, 1, 6'd7, 1, "R4 R5 high kept");
    cyc(1, 6'd7, 8'hE5, 1, 6'd6, 1, "R4 high");
    cyc(0, 0, 0, 1, 6'd7, 1, "R5 high");
    cyc(0, 0, 0, 1, 6'd63, 1, "R5 last");
    shape_nib = 0;
    cyc(0, 0, 0, 1, 6'd3, 1, "R10 byte view");
  endtask

  task automatic t_gate;
    shape_nib = 0;
    cyc(1, 6'd9, 8'h11, 1, 6'd9, 0, "R6 R7 blk off");
    cyc(0, 6'd9, 8'h22, 1, 6'd9, 1, "R6 blk off no write");
    cyc(0, 6'd9, 8'h33, 1, 6'd9, 1, "R6 wen off");
    cyc(0, 0, 0, 0, 6'd5, 1, "R7 ren off hold");
    cyc(0, 0, 0, 1, 6'd5, 0, "R7 blk off hold");
  endtask

  task automatic t_collide;
    shape_nib = 0;
    cyc(1, 6'd12, 8'h77, 1, 6'd12, 1, "R8 byte old");
    cyc(0, 0, 0, 1, 6'd12, 1, "R8 byte new");
    shape_nib = 1;
    cyc(1, 6'd25, 8'h0B, 1, 6'd25, 1, "R8 nib old");
    cyc(0, 0, 0, 1, 6'd25, 1, "R8 nib new");
  endtask

  initial begin
    @(posedge clk); #1;
    t_reset;
    t_byte;
    t_nibble;
    t_gate;
    t_collide;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule